// File: doc/BRIEF.md
# Serial EEPROM Status and Command Engine

This block is the serial slave front end of a small serial EEPROM. It watches the chip-select, serial clock and serial data pins, decodes the 8-bit instruction that opens every selected frame, and carries out the instructions that act on the 8-bit status register. These are: arm writes, disarm writes, read status and write status. The array data paths sit outside it. It holds the write-arm latch and the busy flag, which both clear at reset. It also holds the protect-enable bit and the two block-protect bits, which keep their retained value across reset (modelled by a parameter).

All pins are oversampled in the system clock domain. A guard submodule grants or refuses each status write against the protect pin and the protect-enable bit. An accepted status write starts a timed write cycle whose length is a parameter in system clock cycles. The protect-enable and block-protect bits go out as plain level outputs for the array write path next to this block. There is no streaming data path: every pin is a plain level with no back-pressure. The serial master is the only one that paces transfers.

Top module: `spi_eep_status_engine`

## Requirements
- R1: Both clock polarities work: with the clock idling low (mode 0) or high (mode 3), serial data is taken on rising clock edges and the output changes after falling edges, most significant bit first.
- R2: The instruction is the first 8 bits after chip-select falls. Arm is 0000_x110 (06h or 0Eh), disarm is 0000_x100 (04h or 0Ch), status read is 05h and status write is 01h. Every other code is ignored.
- R3: An arm instruction sets the write-arm latch (status bit 1) only when chip-select rises after exactly 8 bits.
- R4: A disarm instruction of exactly 8 bits clears the write-arm latch whatever the level of `wp_n`.
- R5: A status write of exactly 16 bits, with the latch set and the guard granting, copies data bits 7, 3 and 2 into protect-enable (status bit 7) and block-protect (status bits 3:2) when chip-select rises. Data bits 6:4, 1 and 0 have no effect.
- R6: A status write while the write-arm latch is clear changes nothing.
- R7: When protect-enable is 1 and `wp_n` is low, status writes are refused and the latch stays set. When protect-enable is 0, a low `wp_n` does not block them.
- R8: An accepted status write keeps `busy` high for `WC_CYCLES` clock cycles. During that time status bits 6:4 and 0 read as ones, and at its end the write-arm latch clears. When idle, bits 6:4 and 0 read as zero.
- R9: While busy, only the status read is served. Arm, disarm and status write frames are dropped.
- R10: After a status-read instruction, the status byte is driven on `so` starting at the next falling clock edge, with `so_oe` high for the rest of the frame.
- R11: While chip-select is high, `so_oe` is low, and clock or data activity changes no state.
- R12: After reset the latch and `busy` are 0, the protection bits equal `NV_INIT`, and a frame starts only on an observed falling edge of chip-select.
- R13: A frame with any bit count other than the one its instruction needs is discarded without changing state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for `so`; low means high impedance |
| wp_en | output | 1 | Protect-enable bit |
| blk_prot | output | 2 | Block-protect level |
| busy | output | 1 | Timed write cycle running |

## Verification
The bench builds the block with `WC_CYCLES` = 1500 and `NV_INIT` = 0. With that cycle length, a status read, a dropped disarm and a second status read all fit inside one write cycle, so the ones in the reserved bits and the refusal of commands can be seen at the pins. The serial clock runs at 16 system clocks per bit, and both clock polarities are used. With `NV_INIT` at zero, every protection state the bench reaches comes from a granted write and not from the reset value.

// File: rtl/spi_eep_pkg.sv
package spi_eep_pkg;
  localparam int OP_W = 8;
  localparam logic [7:0] OP_RDSTAT = 8'h05;
  localparam logic [7:0] OP_WRSTAT = 8'h01;
  localparam logic [7:0] ARM_MASK  = 8'hF7;
  localparam logic [7:0] OP_ARM    = 8'h06;
  localparam logic [7:0] OP_DISARM = 8'h04;

  localparam int ST_PEN  = 7;
  localparam int ST_BPHI = 3;
  localparam int ST_BPLO = 2;
  localparam int ST_WEL  = 1;
  localparam int ST_BSY  = 0;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_ARM, CMD_DISARM, CMD_RDSTAT, CMD_WRSTAT
  } cmd_e;

  function automatic cmd_e decode_op(input logic [7:0] op);
    if ((op & ARM_MASK) == OP_ARM)         return CMD_ARM;
    else if ((op & ARM_MASK) == OP_DISARM) return CMD_DISARM;
    else if (op == OP_RDSTAT)              return CMD_RDSTAT;
    else if (op == OP_WRSTAT)              return CMD_WRSTAT;
    else                                   return CMD_NONE;
  endfunction
endpackage

// File: rtl/spi_eep_pin_sync.sv
module spi_eep_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic cs_fall,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_lvl
);
  localparam int NPIN = 3;
  logic [NPIN-1:0] pin_raw;
  logic [NPIN-1:0] pin_s;
  logic [NPIN-1:0] pin_d;

  assign pin_raw = {si, sck, cs_n};

  genvar g;
  generate
    for (g = 0; g < NPIN; g++) begin : g_pin
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], pin_raw[g]};
      end
      assign pin_s[g] = sh[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_d <= '0;
    else        pin_d <= pin_s;
  end

  assign cs_fall  = !pin_s[0] &&  pin_d[0];
  assign cs_rise  =  pin_s[0] && !pin_d[0];
  assign sck_rise =  pin_s[1] && !pin_d[1];
  assign sck_fall = !pin_s[1] &&  pin_d[1];
  assign si_lvl   =  pin_s[2];
endmodule

// File: rtl/spi_eep_frame_rx.sv
module spi_eep_frame_rx #(
  parameter int FRAME_BITS = 16,
  parameter int CW = $clog2(FRAME_BITS + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_fall,
  input  logic          cs_rise,
  input  logic          sck_rise,
  input  logic          si_lvl,
  output logic          frame_act,
  output logic [7:0]    opcode,
  output logic [7:0]    payload,
  output logic [CW-1:0] bit_cnt,
  output logic          op_done,
  output logic          eof
);
  localparam logic [CW-1:0] OVER     = CW'(FRAME_BITS + 1);
  localparam logic [CW-1:0] OP_LAST  = CW'(7);
  localparam logic [CW-1:0] DAT_LAST = CW'(FRAME_BITS - 1);

  logic [7:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_act <= 1'b0;
      sr        <= '0;
      opcode    <= '0;
      payload   <= '0;
      bit_cnt   <= '0;
      op_done   <= 1'b0;
    end else begin
      op_done <= 1'b0;
      if (cs_fall) begin
        frame_act <= 1'b1;
        bit_cnt   <= '0;
      end else if (cs_rise) begin
        frame_act <= 1'b0;
      end else if (sck_rise && frame_act) begin
        sr <= {sr[6:0], si_lvl};
        if (bit_cnt != OVER) bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == OP_LAST) begin
          opcode  <= {sr[6:0], si_lvl};
          op_done <= 1'b1;
        end
        if (bit_cnt == DAT_LAST) payload <= {sr[6:0], si_lvl};
      end
    end
  end

  assign eof = cs_rise && frame_act;
endmodule

// File: rtl/spi_eep_wsr_guard.sv
module spi_eep_wsr_guard (
  input  logic wel,
  input  logic pen,
  input  logic wp_n,
  input  logic busy,
  output logic grant
);
  logic hw_locked;
  assign hw_locked = pen && !wp_n;
  assign grant     = wel && !hw_locked && !busy;
endmodule

// File: rtl/spi_eep_wc_timer.sv
module spi_eep_wc_timer #(
  parameter int WC_CYCLES = 1000,
  parameter int TW = $clog2(WC_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam logic [TW-1:0] LOAD = TW'(WC_CYCLES);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= LOAD;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == TW'(1)) && !start;
endmodule

// File: rtl/spi_eep_status_engine.sv
module spi_eep_status_engine
  import spi_eep_pkg::*;
#(
  parameter int         WC_CYCLES  = 100000,
  parameter logic [7:0] NV_INIT    = 8'h00,
  parameter int         SYNC_STAGES = 2,
  parameter int         FRAME_BITS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       si,
  input  logic       wp_n,
  output logic       so,
  output logic       so_oe,
  output logic       wp_en,
  output logic [1:0] blk_prot,
  output logic       busy
);
  localparam int CW = $clog2(FRAME_BITS + 2);
  localparam logic [CW-1:0] CNT_OP  = CW'(OP_W);
  localparam logic [CW-1:0] CNT_WRS = CW'(FRAME_BITS);

  logic cs_fall, cs_rise, sck_rise, sck_fall, si_lvl;
  logic frame_act, op_done, eof;
  logic [7:0] opcode, payload;
  logic [CW-1:0] bit_cnt;
  logic wel_q, pen_q;
  logic [1:0] bp_q;
  logic grant, tmr_busy, tmr_done, wc_start;
  logic rd_mode;
  logic [7:0] out_sr;
  logic so_q;
  logic [7:0] stat_view;
  cmd_e end_cmd;

  spi_eep_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .si_lvl(si_lvl)
  );

  spi_eep_frame_rx #(.FRAME_BITS(FRAME_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .si_lvl(si_lvl), .frame_act(frame_act),
    .opcode(opcode), .payload(payload), .bit_cnt(bit_cnt),
    .op_done(op_done), .eof(eof)
  );

  spi_eep_wsr_guard u_guard (
    .wel(wel_q), .pen(pen_q), .wp_n(wp_n), .busy(tmr_busy), .grant(grant)
  );

  spi_eep_wc_timer #(.WC_CYCLES(WC_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(wc_start), .busy(tmr_busy), .done(tmr_done)
  );

  assign end_cmd  = decode_op(opcode);
  assign wc_start = eof && (end_cmd == CMD_WRSTAT) && (bit_cnt == CNT_WRS) && grant;

  always_comb begin
    stat_view          = '0;
    stat_view[ST_PEN]  = pen_q;
    stat_view[6:4]     = {3{tmr_busy}};
    stat_view[ST_BPHI] = bp_q[1];
    stat_view[ST_BPLO] = bp_q[0];
    stat_view[ST_WEL]  = wel_q;
    stat_view[ST_BSY]  = tmr_busy;
  end

  // status register: volatile latch and retained protection bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q <= 1'b0;
      pen_q <= NV_INIT[ST_PEN];
      bp_q  <= {NV_INIT[ST_BPHI], NV_INIT[ST_BPLO]};
    end else begin
      if (tmr_done) wel_q <= 1'b0;
      if (eof && !tmr_busy && bit_cnt == CNT_OP) begin
        if (end_cmd == CMD_ARM)    wel_q <= 1'b1;
        if (end_cmd == CMD_DISARM) wel_q <= 1'b0;
      end
      if (wc_start) begin
        pen_q <= payload[ST_PEN];
        bp_q  <= {payload[ST_BPHI], payload[ST_BPLO]};
      end
    end
  end

  // read path: status byte rotated out on falling serial clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_mode <= 1'b0;
      out_sr  <= '0;
      so_q    <= 1'b0;
    end else begin
      if (cs_fall || cs_rise) begin
        rd_mode <= 1'b0;
      end else if (op_done && decode_op(opcode) == CMD_RDSTAT) begin
        rd_mode <= 1'b1;
        out_sr  <= stat_view;
      end else if (sck_fall && rd_mode) begin
        so_q   <= out_sr[7];
        out_sr <= {out_sr[6:0], out_sr[7]};
      end
    end
  end

  assign so       = so_q && so_oe;
  assign so_oe    = rd_mode && frame_act;
  assign wp_en    = pen_q;
  assign blk_prot = bp_q;
  assign busy     = tmr_busy;
endmodule

// File: rtl/spi_eep_sva.sv
module spi_eep_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       so_oe,
  input logic       wp_en,
  input logic [1:0] blk_prot,
  input logic       busy,
  input logic       wel
);
  // R11: output stays off once deselect has propagated
  assert_so_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) |-> !so_oe);

  // R5: protection bits only move when a write cycle starts
  assert_nv_with_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({wp_en, blk_prot}) |-> $rose(busy));

  // R8: latch is clear when the write cycle ends
  assert_wel_clear_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);

  // R9: latch never gets armed during a write cycle
  assert_no_arm_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> !busy);

  // R12: reset leaves latch and busy clear
  assert_reset_clear_R12: assert property (@(posedge clk)
    !rst_n |=> !busy && !wel);
endmodule

bind spi_eep_status_engine spi_eep_sva u_sva (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so_oe(so_oe), .wp_en(wp_en),
  .blk_prot(blk_prot), .busy(busy), .wel(wel_q)
);

// File: tb/sim_spi_eep_status_engine.sv
`timescale 1ns/1ps
module sim_spi_eep_status_engine;
  localparam int WC = 1500;
  localparam int HP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b0, sck = 1'b0, si = 1'b0, wp_n = 1'b1;
  logic so, so_oe, wp_en, busy;
  logic [1:0] blk_prot;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  // reference model
  bit m_wel = 0, m_pen = 0;
  bit [1:0] m_bp = 0;
  int m_left = 0;
  int pend = 0, p_bits = 0;
  logic [7:0] p_op = 0, p_dat = 0;
  bit p_wp = 1;
  int cs_hi = 0;

  always #5 clk = ~clk;

  spi_eep_status_engine #(.WC_CYCLES(WC), .NV_INIT(8'h00)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .wp_n(wp_n),
    .so(so), .so_oe(so_oe), .wp_en(wp_en), .blk_prot(blk_prot), .busy(busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_status();
    bit b = (m_left > 0);
    return {m_pen, {3{b}}, m_bp, m_wel, b};
  endfunction

  function automatic void m_apply();
    bit b = (m_left > 0);
    bit is_arm = ((p_op & 8'hF7) == 8'h06);
    bit is_dis = ((p_op & 8'hF7) == 8'h04);
    if (!b && p_bits == 8 && is_arm) m_wel = 1;          // R3, R2
    if (!b && p_bits == 8 && is_dis) m_wel = 0;          // R4
    if (!b && p_bits == 16 && p_op == 8'h01 && m_wel && !(m_pen && !p_wp)) begin
      m_pen  = p_dat[7];                                 // R5
      m_bp   = p_dat[3:2];
      m_left = WC;                                       // R8
    end
  endfunction

  // per-clock comparison against the model, away from the edge
  always @(posedge clk) begin
    #2;
    cyc++;
    if (rst_n) begin
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) m_wel = 0;
      end
      if (pend > 0) begin
        pend--;
        if (pend == 0) m_apply();
      end
      cs_hi = cs_n ? cs_hi + 1 : 0;
      check("R5 wp_en", wp_en, m_pen);
      check("R5 blk_prot", blk_prot, m_bp);
      check("R8 busy", busy, m_left > 0);
      if (cs_hi >= 4) check("R11 so_oe", so_oe, 1'b0);
    end
    if (cyc > 190000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one selected frame; returns byte read in bits 8..15
  task automatic xfer(input bit m3, input int nbits, input logic [15:0] tx,
                      output logic [7:0] rx, output logic [7:0] exp_rd);
    rx = 0; exp_rd = 0;
    @(negedge clk);
    sck = m3;
    clks(HP);
    cs_n = 0;
    clks(HP);
    for (int i = 0; i < nbits; i++) begin
      if (m3) sck = 0;
      si = tx[15 - i];
      if (i == 8) exp_rd = m_status();
      clks(HP);
      if (i >= 8 && i < 16) rx[15 - i] = so;
      sck = 1;
      clks(HP);
      if (!m3) sck = 0;
    end
    clks(HP);
    cs_n = 1;
    p_op = tx[15:8]; p_dat = tx[7:0]; p_bits = nbits; p_wp = wp_n;
    pend = 3;
    clks(12);
  endtask

  task automatic cmd(input bit m3, input int nbits, input logic [15:0] tx);
    logic [7:0] r, e;
    xfer(m3, nbits, tx, r, e);
  endtask

  task automatic rdsr(input bit m3, input string req);
    logic [7:0] r, e;
    xfer(m3, 16, 16'h0500, r, e);
    check(req, r, e);
  endtask

  initial begin
    // R12: chip-select low through reset, no falling edge afterwards
    clks(4);
    check("R12 busy at reset", busy, 1'b0);
    check("R12 so_oe at reset", so_oe, 1'b0);
    rst_n = 1;
    clks(4);
    for (int i = 0; i < 8; i++) begin
      si = (8'h06 >> (7 - i)) & 1; clks(HP); sck = 1; clks(HP); sck = 0;
    end
    cs_n = 1;
    clks(20);
    check("R12 protection reset", {wp_en, blk_prot}, 3'b000);
    rdsr(0, "R12 latch clear with no CS fall");

    // R11: serial activity while deselected
    for (int i = 0; i < 8; i++) begin
      si = (8'h06 >> (7 - i)) & 1; clks(HP); sck = 1; clks(HP); sck = 0;
    end
    clks(10);
    rdsr(0, "R11 deselected activity ignored");

    // R3 / R4 / R2
    cmd(0, 8, 16'h0600);
    rdsr(0, "R3 arm sets latch");
    wp_n = 0;
    cmd(0, 8, 16'h0400);
    rdsr(0, "R4 disarm with wp low");
    wp_n = 1;
    cmd(1, 8, 16'h0E00);
    rdsr(1, "R2 arm with bit3 set");
    cmd(1, 8, 16'h0C00);
    rdsr(1, "R2 disarm with bit3 set");
    cmd(0, 8, 16'h0300);
    rdsr(0, "R2 unknown code ignored");

    // R13 truncated frames
    cmd(0, 7, 16'h0600);
    rdsr(0, "R13 short arm dropped");
    cmd(0, 9, 16'h0600);
    rdsr(0, "R13 long arm dropped");

    // R6 write without latch
    cmd(0, 16, 16'h018C);
    rdsr(0, "R6 write without latch");

    // R5 / R8 / R9 / R1 in mode 3
    cmd(1, 8, 16'h0600);
    cmd(1, 16, 16'h01FF);
    rdsr(1, "R8 busy status ones");
    cmd(1, 8, 16'h0400);
    rdsr(1, "R9 disarm dropped while busy");
    cmd(1, 16, 16'h0100);
    clks(WC + 50);
    rdsr(0, "R8 latch cleared after cycle");
    check("R5 only bits 7,3,2 taken", {wp_en, blk_prot}, 3'b111);

    // R7 hardware protect
    cmd(0, 8, 16'h0600);
    wp_n = 0;
    cmd(0, 16, 16'h0100);
    rdsr(0, "R7 locked write refused");
    check("R7 busy stays low", busy, 1'b0);
    wp_n = 1;
    cmd(0, 16, 16'h0108);
    clks(WC + 50);
    rdsr(0, "R5 write clears enable");
    cmd(0, 8, 16'h0600);
    wp_n = 0;
    cmd(0, 16, 16'h0174);
    clks(WC + 50);
    rdsr(0, "R7 pin ignored when disabled");
    wp_n = 1;

    // R13 truncated write, then R10 status read shows latch kept
    cmd(0, 8, 16'h0600);
    cmd(0, 12, 16'h0180);
    rdsr(1, "R13 short write dropped");
    rdsr(0, "R10 status read mode 0");

    clks(20);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule